// File: doc/BRIEF.md
# Bitplane Fetch Slot Sequencer

This block decides, for every cycle of a raster line, whether the display controller should fetch a word for one of up to eight bitplanes, and which plane. A beam position counter runs from 0 to the programmed line length minus one. When bitplane DMA is enabled and the counter reaches the window start, the block repeats fetch units of 8, 4 or 2 cycles. Each cycle of a unit belongs to one plane in a fixed interleaved order. The slot is used only if that plane is among the enabled planes.

When the beam reaches the window stop, the block completes the current unit and then runs one more unit. In that final unit it pulses a modulo strobe so that the pointer logic outside the block can add the per-plane modulo. Some slots are needed for memory refresh: slots 1, 3 and 5, and the last slots of the line. A fetch that lands on one of them raises a conflict flag, unless variable-beam mode is on. If the line ends while the closing units are still running, the fetches that are left carry over into the first slots of the next line. Normal fetching on the new line cancels this carry-over.

Top module: `fb_fetch_seq`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it falls, all four outputs are 0. The beam position restarts at 0.
- R2: With `unit_sel`=2'b00 (8-cycle unit), unit offsets 0..7 map to planes 7,3,5,1,6,2,4,0.
- R3: With `unit_sel`=2'b01 (4-cycle unit), unit offsets 0..3 map to planes 3,1,2,0.
- R4: With `unit_sel`=2'b10 or 2'b11 (2-cycle unit), unit offsets 0 and 1 map to planes 1 and 0.
- R5: A slot raises `req_valid` only if its plane number is less than `plane_cnt`. Otherwise the slot is idle and all outputs stay 0 for it.
- R6: The outputs for beam position h appear on the clock edge that ends position h.
  - If `dma_en` is high at h equal to `win_start`, that position is offset 0 of the first unit.
  - When h equals `win_stop`, the current unit finishes, one more full unit runs, and then no slot is used until the next line.
  - While `dma_en` is low, no request is issued.
- R7: `mod_add` pulses only together with a request. The request must be in the unit that follows the one containing the stop, and its unit offset must be at least `mod_cycle`.
- R8: `refresh_conflict` is 1 together with a request at position 1, 3 or 5, or at a position within `REFRESH_TAIL` of the end of the line. This holds only while `vbeam_mode` is 0; when `vbeam_mode` is 1 the flag stays 0.
- R9: The line may end after the stop was seen but before the unit containing it finished. In that case the next line starts with the rest of that unit followed by one full unit, with no modulo pulse. The plane of next-line position p uses offset (p + saved offset) modulo the unit length.
- R10: The line may instead end during the final (modulo) unit. In that case only the rest of that unit carries over to the start of the next line, and the modulo rule of R7 applies to those slots.
- R11: Nothing carries over into the next line in any of these cases: the stop was not reached when the line ended, `dma_en` was low at the last position, or `plane_cnt` was 0.
- R12: A carry-over still pending when the new line reaches `win_start` with `dma_en` high is dropped. From that position on, the slot order follows the newly started unit at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| line_len | input | HPOS_W | Cycles per line; positions 0..line_len-1 |
| win_start | input | HPOS_W | Beam position of the first fetch unit |
| win_stop | input | HPOS_W | Beam position of the display stop |
| unit_sel | input | 2 | Unit length: 00 = 8, 01 = 4, 1x = 2 cycles |
| plane_cnt | input | 4 | Number of enabled planes (0..8) |
| mod_cycle | input | 3 | First unit offset that takes the modulo |
| dma_en | input | 1 | Bitplane DMA enable |
| vbeam_mode | input | 1 | Variable-beam mode; suppresses the conflict flag |
| req_valid | output | 1 | Fetch request for the slot just ended |
| req_plane | output | 3 | Plane number of the request |
| mod_add | output | 1 | Add the modulo for this plane after the fetch |
| refresh_conflict | output | 1 | Request falls on a refresh slot |

## Verification
The hardest states to reach are the two carry-over cases, because the line has to end at a chosen point inside a chosen unit. The bench puts the window start and stop near the end of a 40-cycle line. It picks them so that the wrap falls either in the unit containing the stop or in the modulo unit, with the offset at the wrap known in advance. It then records the next line slot by slot. For cancellation, the window start is moved earlier in the middle of the first line. The restarted unit then overlaps a carry-over that is still pending, and the two possible plane sequences differ at that position.

// File: rtl/fb_pkg.sv
package fb_pkg;
  localparam int FB_OFF_W  = 3;
  localparam int FB_PCNT_W = FB_OFF_W + 1;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_RUN,
    FS_STOP1,
    FS_STOP2,
    FS_DONE
  } fetch_st_t;

  function automatic logic [FB_OFF_W-1:0] unit_mask(input logic [1:0] sel);
    case (sel)
      2'b00:   return FB_OFF_W'(7);
      2'b01:   return FB_OFF_W'(3);
      default: return FB_OFF_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/fb_beam.sv
module fb_beam #(
  parameter int HPOS_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HPOS_W-1:0] line_len,
  output logic [HPOS_W-1:0] hpos,
  output logic              wrap
);
  assign wrap = (hpos >= line_len - HPOS_W'(1));

  always_ff @(posedge clk) begin
    if (rst)       hpos <= '0;
    else if (wrap) hpos <= '0;
    else           hpos <= hpos + HPOS_W'(1);
  end
endmodule

// File: rtl/fb_slot_map.sv
module fb_slot_map
  import fb_pkg::*;
(
  input  logic [FB_OFF_W-1:0] off,
  input  logic [FB_OFF_W-1:0] mask,
  output logic [FB_OFF_W-1:0] plane
);
  logic [FB_OFF_W-1:0] inv;
  logic [FB_OFF_W-1:0] rev_all [1:FB_OFF_W];

  assign inv = ~off & mask;

  // plane = bit-reversed complement of the offset over the unit's width
  for (genvar g = 1; g <= FB_OFF_W; g++) begin : g_width
    for (genvar b = 0; b < FB_OFF_W; b++) begin : g_bit
      if (b < g) begin : g_use
        assign rev_all[g][b] = inv[g-1-b];
      end else begin : g_zero
        assign rev_all[g][b] = 1'b0;
      end
    end
  end

  always_comb begin
    plane = '0;
    for (int k = 1; k <= FB_OFF_W; k++)
      if (mask == FB_OFF_W'((1 << k) - 1)) plane = rev_all[k];
  end
endmodule

// File: rtl/fb_refresh.sv
module fb_refresh #(
  parameter int HPOS_W = 9,
  parameter int TAIL   = 2
) (
  input  logic [HPOS_W-1:0] hpos,
  input  logic [HPOS_W-1:0] line_len,
  input  logic              suppress,
  output logic              is_slot
);
  logic early, late;
  assign early   = (hpos == HPOS_W'(1)) || (hpos == HPOS_W'(3)) || (hpos == HPOS_W'(5));
  assign late    = ({1'b0, hpos} + (HPOS_W+1)'(TAIL)) >= {1'b0, line_len};
  assign is_slot = !suppress && (early || late);
endmodule

// File: rtl/fb_fetch_seq.sv
module fb_fetch_seq
  import fb_pkg::*;
#(
  parameter int HPOS_W       = 9,
  parameter int REFRESH_TAIL = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [HPOS_W-1:0]    line_len,
  input  logic [HPOS_W-1:0]    win_start,
  input  logic [HPOS_W-1:0]    win_stop,
  input  logic [1:0]           unit_sel,
  input  logic [FB_PCNT_W-1:0] plane_cnt,
  input  logic [FB_OFF_W-1:0]  mod_cycle,
  input  logic                 dma_en,
  input  logic                 vbeam_mode,
  output logic                 req_valid,
  output logic [FB_OFF_W-1:0]  req_plane,
  output logic                 mod_add,
  output logic                 refresh_conflict
);
  localparam int OFF_W = FB_OFF_W;

  logic [HPOS_W-1:0] h;
  logic              wrap;
  fetch_st_t         st, ns, st_eff;
  logic [OFF_W-1:0]  off, noff, umask;
  logic              ovr_pend, ovr_mod;
  logic [HPOS_W-1:0] ovr_end;
  logic [OFF_W-1:0]  ovr_shift;

  logic              start_now, run_now, ovr_now, stop_hit, unit_end;
  logic [OFF_W-1:0]  mask_now, off_now, ovr_off, slot_off, slot_mask, plane;
  logic              fetch_ok, mod_now, ref_slot;
  logic [HPOS_W-1:0] unit_len, left_len;

  fb_beam #(.HPOS_W(HPOS_W)) u_beam (
    .clk(clk), .rst(rst), .line_len(line_len), .hpos(h), .wrap(wrap)
  );

  fb_slot_map u_map (.off(slot_off), .mask(slot_mask), .plane(plane));

  fb_refresh #(.HPOS_W(HPOS_W), .TAIL(REFRESH_TAIL)) u_ref (
    .hpos(h), .line_len(line_len), .suppress(vbeam_mode), .is_slot(ref_slot)
  );

  // slot selection for the current beam position
  always_comb begin
    start_now = (st == FS_IDLE) && dma_en && (h == win_start);
    run_now   = start_now || (st == FS_RUN) || (st == FS_STOP1) || (st == FS_STOP2);
    mask_now  = start_now ? unit_mask(unit_sel) : umask;
    off_now   = start_now ? '0 : off;
    ovr_now   = ovr_pend && !start_now;
    ovr_off   = (h[OFF_W-1:0] + ovr_shift) & umask;
    slot_off  = run_now ? off_now : ovr_off;
    slot_mask = run_now ? mask_now : umask;
    fetch_ok  = (run_now || ovr_now) && dma_en && ({1'b0, plane} < plane_cnt);
    mod_now   = fetch_ok && (slot_off >= mod_cycle) &&
                (run_now ? (st == FS_STOP2) : ovr_mod);
  end

  // window progression
  always_comb begin
    st_eff   = start_now ? FS_RUN : st;
    stop_hit = run_now && (h == win_stop) && (st_eff == FS_RUN);
    unit_end = (off_now == mask_now);
    ns       = st;
    noff     = off;
    if (run_now) begin
      noff = (off_now + OFF_W'(1)) & mask_now;
      case (st_eff)
        FS_RUN:   ns = unit_end ? (stop_hit ? FS_STOP2 : FS_RUN)
                                : (stop_hit ? FS_STOP1 : FS_RUN);
        FS_STOP1: ns = unit_end ? FS_STOP2 : FS_STOP1;
        FS_STOP2: ns = unit_end ? FS_DONE  : FS_STOP2;
        default:  ns = st_eff;
      endcase
    end
    unit_len = HPOS_W'(mask_now) + HPOS_W'(1);
    left_len = unit_len - HPOS_W'(noff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= FS_IDLE;
      off       <= '0;
      umask     <= unit_mask(2'b00);
      ovr_pend  <= 1'b0;
      ovr_mod   <= 1'b0;
      ovr_end   <= '0;
      ovr_shift <= '0;
    end else begin
      umask <= mask_now;
      if (wrap) begin
        st        <= FS_IDLE;
        off       <= '0;
        ovr_shift <= noff;
        ovr_pend  <= 1'b0;
        ovr_mod   <= 1'b0;
        ovr_end   <= '0;
        if (dma_en && (plane_cnt != '0)) begin
          if (ns == FS_STOP1) begin
            ovr_pend <= 1'b1;
            ovr_end  <= left_len + unit_len;
          end else if (ns == FS_STOP2) begin
            ovr_pend <= 1'b1;
            ovr_mod  <= 1'b1;
            ovr_end  <= left_len;
          end
        end
      end else begin
        st  <= ns;
        off <= noff;
        if (start_now)
          ovr_pend <= 1'b0;
        else if (ovr_pend && (h == ovr_end - HPOS_W'(1)))
          ovr_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid        <= 1'b0;
      req_plane        <= '0;
      mod_add          <= 1'b0;
      refresh_conflict <= 1'b0;
    end else begin
      req_valid        <= fetch_ok;
      req_plane        <= fetch_ok ? plane : '0;
      mod_add          <= mod_now;
      refresh_conflict <= fetch_ok && ref_slot;
    end
  end

  // R5: a request never names a plane outside the enabled count
  assert_plane_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ({1'b0, req_plane} < $past(plane_cnt)));

  // R6: disabled DMA issues no request
  assert_no_req_when_off_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(dma_en) |-> !req_valid);

  // R7: modulo strobe only travels with a fetch
  assert_mod_with_req_R7: assert property (@(posedge clk) disable iff (rst)
    mod_add |-> req_valid);

  // R8: conflict needs a fetch and no variable-beam mode
  assert_conflict_gated_R8: assert property (@(posedge clk) disable iff (rst)
    refresh_conflict |-> (req_valid && !$past(vbeam_mode)));

  // R9: a pending carry-over always lies ahead of the beam
  assert_ovr_ahead_R9: assert property (@(posedge clk) disable iff (rst)
    ovr_pend |-> (h < ovr_end));

  // R1: outputs come out of reset cleared
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!req_valid && !mod_add && !refresh_conflict));
endmodule

// File: tb/sim_fb_fetch_seq.sv
`timescale 1ns/1ps
module sim_fb_fetch_seq;
  localparam int HW = 9;
  localparam int NREC = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [HW-1:0] line_len = 9'd40, win_start = '0, win_stop = '0;
  logic [1:0] unit_sel = 2'b00;
  logic [3:0] plane_cnt = '0;
  logic [2:0] mod_cycle = '0;
  logic dma_en = 1'b0, vbeam_mode = 1'b0;
  logic req_valid, mod_add, refresh_conflict;
  logic [2:0] req_plane;

  always #5 clk = ~clk;

  fb_fetch_seq u0 (
    .clk(clk), .rst(rst), .line_len(line_len), .win_start(win_start),
    .win_stop(win_stop), .unit_sel(unit_sel), .plane_cnt(plane_cnt),
    .mod_cycle(mod_cycle), .dma_en(dma_en), .vbeam_mode(vbeam_mode),
    .req_valid(req_valid), .req_plane(req_plane), .mod_add(mod_add),
    .refresh_conflict(refresh_conflict)
  );

  int n_chk = 0, n_fail = 0;
  int rec_n = 0;
  bit rec_on = 0;
  logic       lv [NREC];
  logic [2:0] lp [NREC];
  logic       lm [NREC];
  logic       lc [NREC];

  // index k = k-th beam position after reset release (line = k/40)
  always @(posedge clk) begin
    #2;
    if (rec_on && rec_n < NREC) begin
      lv[rec_n] = req_valid;
      lp[rec_n] = req_plane;
      lm[rec_n] = mod_add;
      lc[rec_n] = refresh_conflict;
      rec_n++;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic restart(input logic [1:0] us, input int cnt, input int ws, input int wp,
                         input int mc, input bit en, input bit vb, input int n);
    @(negedge clk);
    rec_on = 0; rst = 1;
    unit_sel = us; plane_cnt = 4'(cnt); win_start = HW'(ws); win_stop = HW'(wp);
    mod_cycle = 3'(mc); dma_en = en; vbeam_mode = vb;
    repeat (2) @(negedge clk);
    rst = 0; rec_n = 0; rec_on = 1;
    while (rec_n < n) @(negedge clk);
  endtask

  task automatic test_reset();
    @(negedge clk);
    rec_on = 0; rst = 1; dma_en = 1; plane_cnt = 8; win_start = 0;
    repeat (3) @(negedge clk);
    check("R1", "valid in reset", int'(req_valid), 0);
    check("R1", "conflict in reset", int'(refresh_conflict), 0);
    rst = 0; rec_n = 0; rec_on = 1;
    while (rec_n < 2) @(negedge clk);
    // start 0 -> position 0 is offset 0 (plane 7), beam restarted at 0
    check("R1", "plane at pos0 after reset", int'(lp[0]), 7);
  endtask

  task automatic test_order8();
    int exp8 [8] = '{7, 3, 5, 1, 6, 2, 4, 0};
    int nm = 0;
    restart(2'b00, 8, 8, 20, 5, 1, 0, 40);
    check("R6", "idle before start", int'(lv[7]), 0);
    for (int k = 0; k < 8; k++) check("R2", "8-unit plane", int'(lp[8+k]), exp8[k]);
    check("R6", "last closing fetch", int'(lv[31]), 1);
    check("R6", "idle after closing unit", int'(lv[32]), 0);
    for (int k = 0; k < 40; k++) nm += int'(lm[k]);
    check("R7", "modulo count", nm, 3);
    check("R7", "modulo at offset 5", int'(lm[29]), 1);
    check("R7", "no modulo at offset 4", int'(lm[28]), 0);
  endtask

  task automatic test_order4_gate();
    int nr = 0;
    restart(2'b01, 2, 10, 12, 0, 1, 0, 40);
    for (int k = 0; k < 40; k++) nr += int'(lv[k]);
    check("R5", "requests with 2 planes", nr, 4);
    check("R5", "plane 3 slot idle", int'(lv[10]), 0);
    check("R3", "offset1 plane", int'(lp[11]), 1);
    check("R3", "offset3 plane", int'(lp[13]), 0);
    check("R7", "modulo in final unit", int'(lm[15]), 1);
    check("R7", "no modulo in first unit", int'(lm[11]), 0);
  endtask

  task automatic test_order2_refresh();
    restart(2'b10, 2, 0, 6, 0, 1, 0, 12);
    check("R4", "offset0 plane", int'(lp[0]), 1);
    check("R4", "offset1 plane", int'(lp[1]), 0);
    check("R8", "conflict at 1", int'(lc[1]), 1);
    check("R8", "conflict at 5", int'(lc[5]), 1);
    check("R8", "no conflict at 4", int'(lc[4]), 0);
    check("R6", "end after closing unit", int'(lv[10]), 0);
    restart(2'b11, 2, 0, 6, 0, 1, 1, 8);
    check("R8", "vbeam suppresses at 3", int'(lc[3]), 0);
    check("R4", "sel 11 offset0 plane", int'(lp[0]), 1);
  endtask

  task automatic test_carry_stop1();
    int ex [10] = '{4, 0, 7, 3, 5, 1, 6, 2, 4, 0};
    int nm = 0;
    restart(2'b00, 8, 26, 36, 0, 1, 0, 52);
    check("R8", "tail conflict at 39", int'(lc[39]), 1);
    for (int k = 0; k < 10; k++) check("R9", "carried plane", int'(lp[40+k]), ex[k]);
    check("R9", "carry ends", int'(lv[50]), 0);
    for (int k = 0; k < 52; k++) nm += int'(lm[k]);
    check("R9", "no modulo in carry", nm, 0);
    check("R8", "conflict at next-line 3", int'(lc[43]), 1);
  endtask

  task automatic test_carry_stop2();
    restart(2'b00, 8, 26, 28, 6, 1, 0, 44);
    check("R10", "no modulo at offset5", int'(lm[39]), 0);
    check("R10", "carried offset6 plane", int'(lp[40]), 4);
    check("R10", "carried modulo", int'(lm[40]), 1);
    check("R10", "carried last modulo", int'(lm[41]), 1);
    check("R10", "carry length", int'(lv[42]), 0);
  endtask

  task automatic test_no_carry();
    restart(2'b00, 8, 30, 60, 0, 1, 0, 44);
    check("R11", "no carry when stop unseen", int'(lv[40]), 0);
    check("R11", "no carry slot 2", int'(lv[42]), 0);
    restart(2'b00, 8, 26, 36, 0, 1, 0, 38);
    @(negedge clk); dma_en = 0;
    while (rec_n < 44) @(negedge clk);
    check("R11", "no carry with dma off", int'(lv[41]), 0);
    restart(2'b00, 8, 4, 10, 0, 0, 0, 40);
    check("R6", "dma off no request", int'(lv[6]), 0);
  endtask

  task automatic test_cancel();
    restart(2'b00, 8, 26, 36, 0, 1, 0, 32);
    @(negedge clk); win_start = 3;
    while (rec_n < 48) @(negedge clk);
    check("R12", "carry before restart", int'(lp[42]), 7);
    check("R12", "restart offset0", int'(lp[43]), 7);
    check("R12", "restart offset1", int'(lp[44]), 3);
  endtask

  initial begin
    fork
      begin
        test_reset();
        test_order8();
        test_order4_gate();
        test_order2_refresh();
        test_carry_stop1();
        test_carry_stop2();
        test_no_carry();
        test_cancel();
      end
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule